// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a processor load/store port and a memory port one word wide. The processor presents word accesses with byte addresses and holds each request until the cache answers with a ready pulse. Every block of memory has exactly one possible home in the cache. That home is chosen by the index bits of the address, and a stored tag together with a valid bit tell whether the home currently holds that block. A read that finds its block answers in the same cycle. A read that does not find it stalls the processor. The cache then brings in all four words of the block, one memory transaction per word, records the tag, sets the valid bit and lets the held access complete as a hit.

Stores are write-through. A store updates the cached word and places the word in a small write buffer. The buffer pushes its contents to memory in arrival order while the processor keeps issuing accesses. A store that misses first refills the block and then writes the word. Before a refill reads memory, the buffer must be empty, so a fetch never returns data that a queued store is about to overwrite. A store arriving while the buffer is full waits for a free slot.

Top module: `wt_dcache`

## Requirements
- R1: The byte address is decoded as: tag = bits 31..14, index = bits 13..4, word-in-block = bits 3..2. Bits 1..0 are ignored, so byte addresses 0x109 and 0x108 return the same word.
- R2: Reset clears every valid bit, so the first access to any index after reset misses, even if that index was filled before the reset.
- R3: A read whose tag matches a valid entry asserts cpuReady in the cycle it is presented, with no stall, and returns the stored word on cpuRdata.
- R4: A read miss stalls the processor. It then reads the four words of the block from memory at ascending word addresses, starting at the block base (address with bits 3..0 cleared). After that it installs tag and valid and completes the access with the memory word.
- R5: An access to an index held under a different tag replaces that entry. A later access to the previous tag misses.
- R6: A store hit updates the cached word and completes without a stall while the write buffer has a free slot. A following read returns the stored value.
- R7: A store miss first refills the whole block and then writes the word. The other words of that block read back with their memory values.
- R8: Every store reaches memory as one write transaction, in the order in which the stores completed. Memory finally holds the last value stored to each address.
- R9: With all WB_DEPTH buffer slots occupied, a store is held (cpuReady low) until a slot frees.
- R10: A miss issues no memory read while any store is still waiting in the write buffer.
- R11: Once memReq is raised, memReq, memWe, memAddr and memWdata stay unchanged until the cycle in which memAck is seen.
- R12: A store hit that is accepted in the same cycle as the buffer head retires on memAck leaves the occupancy unchanged. Back-to-back stores against a fast memory never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 for a store, 0 for a load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Access completes at this clock edge |
| cpuRdata | output | 32 | Load data, valid while cpuReady is high on a load |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 for a memory write (buffer drain), 0 for a refill read |
| memAddr | output | 32 | Word-aligned memory byte address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory finishes the current transaction this cycle |
| memRdata | input | 32 | Memory read data, valid with memAck on a read |

## Verification
Two functions can fall on the same clock edge: the write buffer accepting a store hit and the buffer retiring its head on memAck. The bench provokes this with a memory that acknowledges at once and a run of back-to-back store hits, so enqueue and dequeue meet on alternate edges. The coincidence is judged at the ports: none of the stores may stall, every read-back must return the new data, and the memory's write log must show each store once, in order. The bound checker also requires the occupancy to hold across such an edge.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } ctrlState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic fillWord;    // write memRdata into the lane chosen by fillIdx
    logic fillFinish;  // install tag and set valid for the current index
    logic storeWord;   // write cpuWdata into the addressed lane
    logic bufPush;     // enqueue the store into the write buffer
    logic bufPop;      // retire the write buffer head
    logic portFill;    // memory port carries the refill address
  } dpStrobe_t;

endpackage

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [WORD_W-1:0] pushData,
  input  logic              pop,
  output logic [ADDR_W-1:0] headAddr,
  output logic [WORD_W-1:0] headData,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [WORD_W-1:0] dataQ [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  countQ;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
    end
  end

  assign headAddr = addrQ[rdPtr];
  assign headData = dataQ[rdPtr];
  assign empty    = (countQ == '0);
  assign full     = (countQ == CNT_W'(DEPTH));
  assign count    = countQ;

endmodule

// File: rtl/wt_dcache_dpath.sv
module wt_dcache_dpath
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 2,
  parameter int WB_DEPTH = 4,
  localparam int BYTE_W  = $clog2(WORD_W / 8),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int NUM_BLK = 1 << IDX_W,
  localparam int WORDS   = 1 << OFF_W,
  localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [OFF_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic              hit,
  output logic [WORD_W-1:0] cpuRdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic [CNT_W-1:0]  bufCount
);

  // address split: tag | index | word | byte
  logic [TAG_W-1:0] tagF;
  logic [IDX_W-1:0] idxF;
  logic [OFF_W-1:0] wordF;

  assign tagF  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idxF  = cpuAddr[BYTE_W+OFF_W +: IDX_W];
  assign wordF = cpuAddr[BYTE_W +: OFF_W];

  logic [NUM_BLK-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [NUM_BLK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              validQ       <= '0;
    else if (st.fillFinish) validQ[idxF] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.fillFinish) tagQ[idxF] <= tagF;
  end

  assign hit = validQ[idxF] && (tagQ[idxF] == tagF);

  // one storage lane per word of the block
  logic [WORD_W-1:0] laneRd [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] laneQ [NUM_BLK];
    logic              laneWe;

    assign laneWe = (st.fillWord  && (fillIdx == OFF_W'(w))) ||
                    (st.storeWord && (wordF   == OFF_W'(w)));

    always_ff @(posedge clk) begin
      if (laneWe) laneQ[idxF] <= st.fillWord ? memRdata : cpuWdata;
    end

    assign laneRd[w] = laneQ[idxF];
  end

  assign cpuRdata = laneRd[wordF];

  logic [ADDR_W-1:0] headAddr;
  logic [WORD_W-1:0] headData;

  wt_dcache_wbuf #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .DEPTH (WB_DEPTH)
  ) u_wbuf (
    .clk     (clk),
    .rstN    (rstN),
    .push    (st.bufPush),
    .pushAddr(cpuAddr),
    .pushData(cpuWdata),
    .pop     (st.bufPop),
    .headAddr(headAddr),
    .headData(headData),
    .empty   (bufEmpty),
    .full    (bufFull),
    .count   (bufCount)
  );

  assign memAddr  = st.portFill ? {tagF, idxF, fillIdx, {BYTE_W{1'b0}}} : headAddr;
  assign memWdata = headData;

endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             hit,
  input  logic             bufEmpty,
  input  logic             bufFull,
  input  logic             memAck,
  output logic             cpuReady,
  output logic             memReq,
  output logic             memWe,
  output dpStrobe_t        st,
  output logic [OFF_W-1:0] fillIdx
);

  ctrlState_t       state, nextState;
  logic [OFF_W-1:0] fillCnt;
  logic             lastWord;

  assign lastWord = (fillCnt == {OFF_W{1'b1}});
  assign fillIdx  = fillCnt;

  always_comb begin
    st        = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit) begin
            if (!cpuWe) begin
              cpuReady = 1'b1;
            end else if (!bufFull) begin
              cpuReady     = 1'b1;
              st.storeWord = 1'b1;
              st.bufPush   = 1'b1;
            end
          end else begin
            nextState = bufEmpty ? ST_FILL : ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (bufEmpty) nextState = ST_FILL;
      end
      ST_FILL: begin
        st.portFill = 1'b1;
        memReq      = 1'b1;
        if (memAck) begin
          st.fillWord = 1'b1;
          if (lastWord) begin
            st.fillFinish = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    // buffer drain owns the port whenever no refill is running
    if (state != ST_FILL && !bufEmpty) begin
      memReq    = 1'b1;
      memWe     = 1'b1;
      st.bufPop = memAck;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_FILL && memAck) fillCnt <= fillCnt + 1'b1;
      else if (state != ST_FILL)      fillCnt <= '0;
    end
  end

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 2,
  parameter int WB_DEPTH = 4,
  localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRdata
);

  dpStrobe_t        st;
  logic [OFF_W-1:0] fillIdx;
  logic             hit;
  logic             bufEmpty;
  logic             bufFull;
  logic [CNT_W-1:0] bufCount;

  wt_dcache_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .hit     (hit),
    .bufEmpty(bufEmpty),
    .bufFull (bufFull),
    .memAck  (memAck),
    .cpuReady(cpuReady),
    .memReq  (memReq),
    .memWe   (memWe),
    .st      (st),
    .fillIdx (fillIdx)
  );

  wt_dcache_dpath #(
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .IDX_W   (IDX_W),
    .OFF_W   (OFF_W),
    .WB_DEPTH(WB_DEPTH)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .fillIdx (fillIdx),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .hit     (hit),
    .cpuRdata(cpuRdata),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .bufEmpty(bufEmpty),
    .bufFull (bufFull),
    .bufCount(bufCount)
  );

endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic [CNT_W-1:0]  bufCount
);

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)); // R11

  AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> bufCount == '0); // R10

  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> !cpuReady); // R4

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= CNT_W'(DEPTH)); // R9

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && bufCount == CNT_W'(DEPTH) |-> !cpuReady); // R9

  AST_STORE_ENQUEUES: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuWe && !(memAck && memWe) |=> bufCount == $past(bufCount) + CNT_W'(1)); // R6

  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuWe && memAck && memWe |=> bufCount == $past(bufCount)); // R12

endmodule

bind wt_dcache wt_dcache_chk #(
  .ADDR_W(ADDR_W),
  .WORD_W(WORD_W),
  .DEPTH (WB_DEPTH)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuReady(cpuReady),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAck  (memAck),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .bufCount(bufCount)
);

// File: tb/wt_dcache_tb.sv
`timescale 1ns/1ps
module wt_dcache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #2.5 clk = ~clk;

  wt_dcache u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // memory model and reference state
  logic [31:0] memStore [logic [29:0]];
  logic [31:0] refMem   [logic [29:0]];
  int          memLat = 2;
  int          waitCnt = 0;
  logic [31:0] wlogA [64];
  logic [31:0] wlogD [64];
  int          wN = 0;
  logic [31:0] rlogA [256];
  int          rN = 0;
  int          orderViol = 0;
  logic [31:0] issA [64];
  logic [31:0] issD [64];
  int          commitCnt = 0;

  function automatic logic [31:0] defWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h3C3C_0000;
  endfunction

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memStore.exists(a[31:2])) return memStore[a[31:2]];
    return defWord(a);
  endfunction

  function automatic logic [31:0] refRead(input logic [31:0] a);
    if (refMem.exists(a[31:2])) return refMem[a[31:2]];
    return defWord(a);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt >= memLat) begin
          memAck  = 1'b1;
          waitCnt = 0;
          if (memWe) begin
            memStore[memAddr[31:2]] = memWdata;
            if (wN < 64) begin wlogA[wN] = memAddr; wlogD[wN] = memWdata; end
            wN++;
          end else begin
            memRdata = memRead(memAddr);
            if (rN < 256) rlogA[rN] = memAddr;
            rN++;
            if (commitCnt != wN) orderViol++;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    #1;
    stalls = 0;
    while (!cpuReady) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    rd = cpuRdata;
    if (we) begin
      refMem[addr[31:2]] = wd;
      issA[commitCnt] = addr;
      issD[commitCnt] = wd;
      commitCnt++;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (wN != commitCnt) @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; cpuReq = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        miss;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_0100, 32'h0,         1'b1, 8'd4},  // R4 cold miss, R2 after reset
    '{1'b0, 32'h0000_0104, 32'h0,         1'b0, 8'd3},  // R3 same block hit
    '{1'b0, 32'h0000_010C, 32'h0,         1'b0, 8'd3},  // R3
    '{1'b0, 32'h0000_0109, 32'h0,         1'b0, 8'd1},  // R1 byte bits ignored
    '{1'b1, 32'h0000_0104, 32'h1111_2222, 1'b0, 8'd6},  // R6 store hit
    '{1'b0, 32'h0000_0104, 32'h0,         1'b0, 8'd6},  // R6 read-back
    '{1'b0, 32'h0000_4100, 32'h0,         1'b1, 8'd5},  // R5 same index, new tag
    '{1'b0, 32'h0000_0100, 32'h0,         1'b1, 8'd5},  // R5 evicted tag misses
    '{1'b0, 32'h0000_0104, 32'h0,         1'b0, 8'd8},  // R8 refill saw stored word
    '{1'b1, 32'h0000_0208, 32'hAAAA_5555, 1'b1, 8'd7},  // R7 store miss
    '{1'b0, 32'h0000_0200, 32'h0,         1'b0, 8'd7},  // R7 neighbour from memory
    '{1'b0, 32'h0000_0208, 32'h0,         1'b0, 8'd7},  // R7 stored word
    '{1'b0, 32'hFFFF_C3F0, 32'h0,         1'b1, 8'd1},  // R1 all-ones tag
    '{1'b0, 32'hFFFF_C3F4, 32'h0,         1'b0, 8'd1}   // R1
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int          stalls;
    int          rStart;
    string       tag;
    logic [31:0] wv [5];

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // reset state
    check(cpuReady == 1'b0, "R2 reset cpuReady", {31'b0, cpuReady}, 32'h0);
    check(memReq == 1'b0,   "R2 reset memReq",   {31'b0, memReq},   32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, stalls);
      $sformat(tag, "R%0d vec%0d stall", VECS[i].req, i);
      check(VECS[i].miss ? (stalls > 0) : (stalls == 0), tag, stalls, {31'b0, VECS[i].miss});
      if (!VECS[i].we) begin
        $sformat(tag, "R%0d vec%0d data", VECS[i].req, i);
        check(rd == refRead(VECS[i].addr), tag, rd, refRead(VECS[i].addr));
      end
    end
    drain();

    // R2: reset invalidates a filled entry; R4: refill order
    applyReset();
    rStart = rN;
    access(1'b0, 32'h0000_0104, 32'h0, rd, stalls);
    check(stalls > 0, "R2 miss after reset", stalls, 32'h1);
    check(rd == refRead(32'h0000_0104), "R2 data after reset", rd, refRead(32'h0000_0104));
    check(rN - rStart == 4, "R4 refill read count", rN - rStart, 32'd4);
    for (int k = 0; k < 4; k++) begin
      check(rlogA[rStart + k] == 32'h0000_0100 + 32'(4 * k), "R4 refill address order",
            rlogA[rStart + k], 32'h0000_0100 + 32'(4 * k));
    end

    // R9: full buffer stalls the fifth back-to-back store
    memLat = 8;
    wv[0] = 32'hB000_0001; wv[1] = 32'hB000_0002; wv[2] = 32'hB000_0003;
    wv[3] = 32'hB000_0004; wv[4] = 32'hB000_0005;
    access(1'b1, 32'h0000_0100, wv[0], rd, stalls);
    check(stalls == 0, "R9 store 1 no stall", stalls, 0);
    access(1'b1, 32'h0000_0104, wv[1], rd, stalls);
    check(stalls == 0, "R9 store 2 no stall", stalls, 0);
    access(1'b1, 32'h0000_0100, wv[2], rd, stalls);
    check(stalls == 0, "R9 store 3 no stall", stalls, 0);
    access(1'b1, 32'h0000_0108, wv[3], rd, stalls);
    check(stalls == 0, "R9 store 4 no stall", stalls, 0);
    access(1'b1, 32'h0000_0100, wv[4], rd, stalls);
    check(stalls > 0, "R9 store 5 stalls on full buffer", stalls, 32'h1);

    // R10: read miss right behind queued stores
    access(1'b0, 32'h8000_0100, 32'h0, rd, stalls);
    check(stalls > 0, "R10 read miss stalls", stalls, 32'h1);
    check(rd == refRead(32'h8000_0100), "R10 read miss data", rd, refRead(32'h8000_0100));
    check(orderViol == 0, "R10 fetch while stores queued", orderViol, 0);
    drain();
    check(memRead(32'h0000_0100) == wv[4], "R8 last store wins", memRead(32'h0000_0100), wv[4]);
    check(memRead(32'h0000_0104) == wv[1], "R8 memory word 0x104", memRead(32'h0000_0104), wv[1]);
    check(memRead(32'h0000_0108) == wv[3], "R8 memory word 0x108", memRead(32'h0000_0108), wv[3]);

    // R12: enqueue and dequeue on the same edge with a zero-latency memory
    memLat = 0;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      a = 32'h8000_0100 + 32'(4 * (k % 4));
      access(1'b1, a, 32'hC000_0000 + 32'(k), rd, stalls);
      check(stalls == 0, "R12 back-to-back store no stall", stalls, 0);
    end
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = 32'h8000_0100 + 32'(4 * k);
      access(1'b0, a, 32'h0, rd, stalls);
      check(stalls == 0 && rd == refRead(a), "R12 read-back", rd, refRead(a));
    end
    drain();
    access(1'b0, 32'h0000_4104, 32'h0, rd, stalls);
    check(rd == refRead(32'h0000_4104), "R10 miss after drain", rd, refRead(32'h0000_4104));
    check(orderViol == 0, "R10 fetch while stores queued", orderViol, 0);
    idle();

    // R8: write transactions in commit order, one per store
    check(wN == commitCnt, "R8 write count", wN, commitCnt);
    for (int k = 0; k < commitCnt && k < 64; k++) begin
      check(wlogA[k][31:2] == issA[k][31:2] && wlogD[k] == issD[k], "R8 write order",
            wlogD[k], issD[k]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule